// File: doc/BRIEF.md
# Per-Channel Blocking Output Generator

This block drives one blocking line in step with a serial T1 or E1 frame carried on a bit clock. Software loads a 32-bit channel mask through a byte-wide write port. For every 8-bit channel time, the line holds the level that the mask and the operating mode select for that channel. The line is intended to gate the clock of an HDLC-style controller so that the controller only sees the chosen time slots.

A frame-sync pulse marks the first bit of channel 1. From that point an internal position counter advances one bit per clock and splits the frame into 32 channels of 8 bits. The channel's level is decided on its first bit and then held. Two inputs change how the mask is read. The line-mode input selects T1 or E1 framing. The rate input selects a 1.544 MHz or 2.048 MHz backplane. In T1, channels 25 to 32 do not exist. On a 2.048 MHz backplane in T1, every fourth slot carries filler and is always blocked. On a 1.544 MHz backplane in E1, the top eight channels never block.

Top module: `chan_gate_gen`

## Requirements
- R1: The mask is four 8-bit registers. A write with `wr_en` high stores `wr_data` into byte `wr_sel`. Byte 0 covers channels 1 to 8, byte 1 covers 9 to 16, byte 2 covers 17 to 24 and byte 3 covers 25 to 32. Bit 0 of each byte is the lowest channel of its group. The other bytes are unchanged by the write.
- R2: The clock in which `frame_sync` is high is bit 0 of channel 1. Each later clock is the next bit, with 8 bits per channel and 32 channels, and the count wraps after channel 32. `blk_out` shows the level for a bit position one clock after that position.
- R3: When a channel's mask bit is 1 and no suppression rule applies, `blk_out` is high for all 8 bits of that channel.
- R4: When a channel's mask bit is 0 and no forcing rule applies, `blk_out` is low for that channel.
- R5: With `mode_e1`=0 (T1), the mask bits for channels 25 to 32 are ignored. Those channels read as 0 unless R6 forces them high.
- R6: With `mode_e1`=0 and `bp_2m`=1, `blk_out` is high whatever the mask holds during channels 5, 9, 13, 17, 21, 25 and 29, and during bits 1 to 7 of channel 1. Bit 0 of channel 1 follows its mask bit.
- R7: With `mode_e1`=1 and `bp_2m`=0, `blk_out` is low during channels 25 to 32.
- R8: `blk_out` changes only on bit 0 of a channel, with one exception: bit 1 of channel 1 under R6.
- R9: A mask write made partway through a channel does not alter that channel's level. It takes effect from the next channel boundary.
- R10: After reset, `blk_out` is low and all mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_sync | input | 1 | High for the clock carrying bit 0 of channel 1 |
| mode_e1 | input | 1 | 0 = T1 framing, 1 = E1 framing |
| bp_2m | input | 1 | 0 = 1.544 MHz backplane, 1 = 2.048 MHz backplane |
| wr_en | input | 1 | Mask byte write strobe |
| wr_sel | input | 2 | Mask byte select |
| wr_data | input | 8 | Mask byte value |
| blk_out | output | 1 | Per-channel blocking line |

## Verification
Assertions check the following on every cycle:
- each write lands in its byte and leaves the other bytes alone;
- a frame sync restarts the position count;
- the line moves only on channel boundaries;
- the forcing and suppression rules hold in each mode and rate pair;
- a set mask bit blocks and a clear one does not, where no rule overrides.

Only the bench's scenarios can show whole-frame behaviour. These scenarios:
- sweep every position of every mode and rate pair under several masks;
- check that after reset every channel is unblocked;
- check that a write landing mid-channel holds off until the next boundary.

// File: rtl/chblk_pkg.sv
package chblk_pkg;
  localparam int NCH          = 32;
  localparam int BITS_PER_CH  = 8;
  localparam int CH_W         = $clog2(NCH);
  localparam int BIT_W        = $clog2(BITS_PER_CH);
  localparam int POS_W        = CH_W + BIT_W;
  localparam int T1_CHANS     = 24;
  localparam int REG_W        = 8;
  localparam int NREG         = NCH / REG_W;
  localparam int SEL_W        = $clog2(NREG);
  localparam int FORCE_STRIDE = 4;
  localparam int STRIDE_W     = $clog2(FORCE_STRIDE);
endpackage

// File: rtl/chblk_mask_regs.sv
module chblk_mask_regs
  import chblk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [REG_W-1:0]       wr_data,
  output logic [NCH-1:0]         mask
);
  for (genvar g = 0; g < NREG; g++) begin : g_byte
    logic             hit;
    logic [REG_W-1:0] byte_d;
    logic [REG_W-1:0] byte_q;

    always_comb begin
      hit    = wr_en && (wr_sel == SEL_W'(g));
      byte_d = hit ? wr_data : byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign mask[g*REG_W +: REG_W] = byte_q;

    // R1: selected byte takes the written value
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(g)) |=> (mask[g*REG_W +: REG_W] == $past(wr_data)));
    // R1: unselected bytes keep their value
    a_r1_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_W'(g)) |=> $stable(mask[g*REG_W +: REG_W]));
  end
endmodule

// File: rtl/chblk_position.sv
module chblk_position
  import chblk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  output logic [CH_W-1:0]   cur_ch,
  output logic [BIT_W-1:0]  cur_bit
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_now;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    pos_now = frame_sync ? '0 : pos_q;
    pos_d   = pos_now + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign cur_ch  = pos_now[POS_W-1:BIT_W];
  assign cur_bit = pos_now[BIT_W-1:0];

  // R2: a sync pulse makes the following clock bit 1 of channel 1
  a_r2_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (pos_q == POS_W'(1)));
  // R2: without sync the position steps by one bit each clock
  a_r2_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> (pos_q == $past(pos_q) + POS_W'(1)));
endmodule

// File: rtl/chblk_level.sv
module chblk_level
  import chblk_pkg::*;
(
  input  logic [NCH-1:0]    mask,
  input  logic [CH_W-1:0]   cur_ch,
  input  logic [BIT_W-1:0]  cur_bit,
  input  logic              mode_e1,
  input  logic              bp_2m,
  input  logic              held,
  output logic              lvl_d
);
  logic boundary;
  logic slot_forced;
  logic beyond;
  logic suppress;
  logic mask_lvl;

  always_comb begin
    boundary    = (cur_bit == '0);
    slot_forced = !mode_e1 && bp_2m
                  && (cur_ch[STRIDE_W-1:0] == '0)
                  && !((cur_ch == '0) && boundary);
    beyond      = (cur_ch >= CH_W'(T1_CHANS));
    suppress    = beyond && !(mode_e1 && bp_2m);
    mask_lvl    = mask[cur_ch] && !suppress;
    if (slot_forced)   lvl_d = 1'b1;
    else if (boundary) lvl_d = mask_lvl;
    else               lvl_d = held;
  end
endmodule

// File: rtl/chan_gate_gen.sv
module chan_gate_gen
  import chblk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_sync,
  input  logic        mode_e1,
  input  logic        bp_2m,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [7:0]  wr_data,
  output logic        blk_out
);
  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  logic [NCH-1:0]   mask;
  logic [CH_W-1:0]  cur_ch;
  logic [BIT_W-1:0] cur_bit;
  logic             lvl_d;
  logic             blk_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  chblk_mask_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .mask(mask)
  );

  chblk_position u_pos (
    .clk(clk), .rst_n(rst_s_n), .frame_sync(frame_sync),
    .cur_ch(cur_ch), .cur_bit(cur_bit)
  );

  chblk_level u_lvl (
    .mask(mask), .cur_ch(cur_ch), .cur_bit(cur_bit),
    .mode_e1(mode_e1), .bp_2m(bp_2m), .held(blk_q), .lvl_d(lvl_d)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) blk_q <= 1'b0;
    else          blk_q <= lvl_d;
  end
  assign blk_out = blk_q;

  // R8: the line moves only on a channel's first bit (or bit 1 of channel 1)
  a_r8_boundary_only: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(blk_q) |-> ($past(cur_bit) == '0
                         || ($past(cur_ch) == '0 && $past(cur_bit) == BIT_W'(1))));
  // R3: set mask bit blocks where nothing overrides
  a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_e1 && bp_2m && cur_bit == '0 && mask[cur_ch]) |=> blk_q);
  // R4: clear mask bit leaves the line low where nothing forces it
  a_r4_clear_low: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_e1 && cur_bit == '0 && !mask[cur_ch]) |=> !blk_q);
  // R5: T1 upper channels ignore the mask
  a_r5_t1_upper: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mode_e1 && cur_bit == '0 && cur_ch >= CH_W'(T1_CHANS)
     && !(bp_2m && cur_ch[STRIDE_W-1:0] == '0)) |=> !blk_q);
  // R6: filler slots forced high
  a_r6_forced: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mode_e1 && bp_2m && cur_ch[STRIDE_W-1:0] == '0
     && !(cur_ch == '0 && cur_bit == '0)) |=> blk_q);
  // R7: E1 on slow backplane never blocks upper channels
  a_r7_e1_upper: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_e1 && !bp_2m && cur_bit == '0 && cur_ch >= CH_W'(T1_CHANS)) |=> !blk_q);
endmodule

// File: tb/chan_gate_gen_bench.sv
module chan_gate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_sync;
  logic       mode_e1;
  logic       bp_2m;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       blk_out;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  chan_gate_gen u_chan_gate_gen (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .mode_e1(mode_e1),
    .bp_2m(bp_2m), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .blk_out(blk_out)
  );

  task automatic check(logic act, logic exp, string tag, int pos);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pos=%0d actual=%0b expected=%0b", tag, pos, act, exp);
    end
  endtask

  function automatic logic exp_lvl(bit e1, bit b2, logic [31:0] m, int ch, int b);
    if (!e1 && b2 && (ch % 4) == 0 && !(ch == 0 && b == 0)) return 1'b1;
    if (ch >= 24 && !(e1 && b2)) return 1'b0;
    return m[ch];
  endfunction

  function automatic string tag_of(bit e1, bit b2, logic [31:0] m, int ch, int b);
    if (!e1 && b2 && (ch % 4) == 0 && !(ch == 0 && b == 0)) return "R6";
    if (ch >= 24 && !e1) return "R5";
    if (ch >= 24 && !b2) return "R7";
    if (m[ch]) return "R3";
    return "R4";
  endfunction

  // R1: byte i holds channels 8i+1..8i+8, LSB lowest
  task automatic write_mask(logic [31:0] m);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'(i); wr_data = m[i*8 +: 8];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sweep(bit e1, bit b2, logic [31:0] m, bit do_write, string force_tag);
    mode_e1 = e1; bp_2m = b2;
    if (do_write) write_mask(m);
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
    for (int k = 0; k < 256; k++) begin
      check(blk_out, exp_lvl(e1, b2, m, k / 8, k % 8),
            (force_tag != "") ? force_tag : tag_of(e1, b2, m, k / 8, k % 8), k);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] masks [4];
    masks[0] = 32'h0000_0000; masks[1] = 32'hFFFF_FFFF;
    masks[2] = 32'hA5C3_3C5A; masks[3] = 32'h0F0F_00FF;
    rst_n = 1'b0; frame_sync = 1'b0; mode_e1 = 1'b1; bp_2m = 1'b1;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(blk_out, 1'b0, "R10", -1);
    // R10: mask is zero after reset, so no channel blocks
    sweep(1'b1, 1'b1, 32'h0, 1'b0, "R10");
    // R1 R2 R3..R7: every mode/rate pair, several masks
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < 4; j++)
        sweep(c[1], c[0], masks[j], 1'b1, "");
    // R9: write mid-channel 4 (channel index 3), bits for channels 4 and 5
    mode_e1 = 1'b1; bp_2m = 1'b1;
    write_mask(32'h0);
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
    for (int k = 0; k < 48; k++) begin
      logic e;
      e = (k >= 32 && k < 40);
      check(blk_out, e, (k >= 27) ? "R9" : "R4", k);
      if (k == 26) begin
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h18;
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule